// File: doc/BRIEF.md
# SDRAM Bring-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface and owns the command pins from reset onward. It first waits out the power-up stabilisation time while holding clock enable and the data mask high. It then plays the start-up sequence: one precharge of every bank, a programmable number of auto-refresh commands, and a load of the mode register with a fixed configuration word placed on the address pins. Each command is followed by its required spacing, counted in clock cycles.

Once the mode register has been loaded and the register-to-activate interval has run out, the block raises `ready_o` and keeps it high. From then on an interval timer marks when a refresh falls due. Each refresh is a precharge of all banks followed by an auto-refresh, because a user access may have left rows open. Between refreshes a one-cycle grant answers a simple request line, which hands the command bus to the user logic for that cycle. A refresh that is due always wins over a request.

Top module: `sdr_bringup_ctrl`

## Requirements
- R1: After reset is released, the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) for exactly T_PWRUP cycles. During that wait cke_o and dqm_o are high, and the same NOP is shown while reset is held.
- R2: Start-up order is precharge-all, then N_INIT_REF auto-refreshes, then mode register set. Precharge-all has code 0010 on {cs_n,ras_n,cas_n,we_n} with addr bit 10 high. Auto-refresh has code 0001. Mode register set has code 0000 with addr equal to MODE_WORD and ba zero.
- R3: Every precharge-all is followed by the next command exactly T_RP cycles later.
- R4: Every auto-refresh is followed by the next command, or by the next grant, exactly T_RFC cycles later.
- R5: ready_o is low under reset and through initialisation. It rises exactly T_RSA cycles after the mode register set and stays high until the next reset. dqm_o goes low when ready_o rises.
- R6: After ready_o rises, the first periodic precharge-all comes T_REFI+1 cycles later, and later ones follow every T_REFI cycles.
- R7: Each periodic refresh is a precharge-all followed by an auto-refresh. The auto-refresh carries addr zero and ba zero.
- R8: gnt_o is high only in a cycle with req_i high, ready_o high, no command on the pins and no refresh due or in progress. With req_i low, gnt_o is low.
- R9: A refresh that has fallen due takes priority over a request. With req_i held high, the grant drops in the cycle before the precharge-all and the refresh still runs on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | User asks for the command bus |
| gnt_o | output | 1 | User owns the command bus this cycle |
| ready_o | output | 1 | Initialisation complete |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | 1 | Data mask |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address pins |

## Verification
The two functions that can meet in one cycle are a refresh falling due and a user request. The bench holds req_i high across a whole refresh interval, so the timer expiry lands on a cycle in which the grant would otherwise be given. It then checks three things: the grant was present on every earlier idle cycle, it is absent in the due cycle and through the precharge-to-refresh spacing, and it comes back exactly T_RFC cycles after the auto-refresh. The interval from one precharge-all to the next is measured to confirm the request did not delay the refresh.

// File: rtl/sdr_bringup_pkg.sv
package sdr_bringup_pkg;

  typedef enum logic [2:0] {ST_WAIT, ST_PALL, ST_REF, ST_MRS, ST_IDLE} state_e;
  typedef enum logic [1:0] {CMD_NOP, CMD_PALL, CMD_REF, CMD_MRS} cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t cmd_pins(cmd_e c);
    unique case (c)
      CMD_PALL: return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_gap_counter.sv
module sdr_gap_counter #(
  parameter int W       = 8,
  parameter int RST_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // final wait cycle: next state may issue its command
  assign done_o = (cnt_q == W'(1));
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = $clog2(PERIOD + 1);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= W'(PERIOD - 1);
    else if (tick_o)    cnt_q <= W'(PERIOD - 1);
    else if (en_i)      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sdr_cmd_encode.sv
module sdr_cmd_encode
  import sdr_bringup_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              BA_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0,
  parameter int              AP_BIT    = 10
) (
  input  cmd_e              cmd_i,
  output pins_t             pins_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] all_banks;

  generate
    if (AP_BIT < ADDR_W) begin : g_ap
      assign all_banks = ADDR_W'(1) << AP_BIT;
    end else begin : g_no_ap
      assign all_banks = '0;
    end
  endgenerate

  assign pins_o = cmd_pins(cmd_i);
  assign ba_o   = '0;

  always_comb begin
    unique case (cmd_i)
      CMD_PALL: addr_o = all_banks;
      CMD_MRS:  addr_o = MODE_WORD;
      default:  addr_o = '0;
    endcase
  end
endmodule

// File: rtl/sdr_bringup_ctrl.sv
module sdr_bringup_ctrl
  import sdr_bringup_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                BA_W       = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD  = 12'h032,
  parameter int                T_PWRUP    = 20000,
  parameter int                T_RP       = 3,
  parameter int                T_RFC      = 7,
  parameter int                T_RSA      = 2,
  parameter int                T_REFI     = 1560,
  parameter int                N_INIT_REF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              gnt_o,
  output logic              ready_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic              dqm_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int GAP_MAX = imax(imax(T_PWRUP, T_RP), imax(T_RFC, T_RSA));
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int REF_W   = $clog2(N_INIT_REF + 1);

  state_e             state_q, state_d, nxt_q, nxt_d;
  logic [REF_W-1:0]   refs_q, refs_d;
  logic               init_q, init_d;
  logic               done_q, done_d;
  logic               pend_q, pend_d;
  logic               cke_q, dqm_q;
  logic               load;
  logic [GAP_W-1:0]   load_val;
  logic               gap_done, tick;
  cmd_e               cmd;
  pins_t              pins;

  sdr_gap_counter #(.W(GAP_W), .RST_VAL(T_PWRUP)) u_gap (
    .clk_i, .rst_ni, .load_i(load), .val_i(load_val), .done_o(gap_done)
  );

  sdr_refresh_timer #(.PERIOD(T_REFI)) u_timer (
    .clk_i, .rst_ni, .en_i(done_q), .tick_o(tick)
  );

  sdr_cmd_encode #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)) u_enc (
    .cmd_i(cmd), .pins_o(pins), .ba_o(ba_o), .addr_o(addr_o)
  );

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    refs_d   = refs_q;
    init_d   = init_q;
    cmd      = CMD_NOP;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_WAIT: if (gap_done) state_d = nxt_q;
      ST_PALL: begin
        cmd      = CMD_PALL;
        load     = 1'b1;
        load_val = GAP_W'(T_RP - 1);
        state_d  = ST_WAIT;
        nxt_d    = ST_REF;
      end
      ST_REF: begin
        cmd      = CMD_REF;
        load     = 1'b1;
        load_val = GAP_W'(T_RFC - 1);
        state_d  = ST_WAIT;
        if (init_q && refs_q > REF_W'(1)) begin
          nxt_d  = ST_REF;
          refs_d = refs_q - 1'b1;
        end else if (init_q) begin
          nxt_d  = ST_MRS;
        end else begin
          nxt_d  = ST_IDLE;
        end
      end
      ST_MRS: begin
        cmd      = CMD_MRS;
        load     = 1'b1;
        load_val = GAP_W'(T_RSA - 1);
        state_d  = ST_WAIT;
        nxt_d    = ST_IDLE;
        init_d   = 1'b0;
      end
      ST_IDLE: if (pend_q) state_d = ST_PALL;
      default: state_d = ST_WAIT;
    endcase
  end

  // refresh due flag; cleared by the refresh command itself
  assign pend_d = tick | (pend_q & (state_q != ST_REF));
  assign done_d = done_q | ((state_q == ST_WAIT) & gap_done & (nxt_q == ST_IDLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      nxt_q   <= ST_PALL;
      refs_q  <= REF_W'(N_INIT_REF);
      init_q  <= 1'b1;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
      cke_q   <= 1'b0;
      dqm_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      refs_q  <= refs_d;
      init_q  <= init_d;
      done_q  <= done_d;
      pend_q  <= pend_d;
      cke_q   <= 1'b1;
      dqm_q   <= ~done_d;
    end
  end

  assign gnt_o   = (state_q == ST_IDLE) & ~pend_q & req_i;
  assign ready_o = done_q;
  assign cke_o   = cke_q;
  assign dqm_o   = dqm_q;
  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;
endmodule

// File: rtl/sdr_bringup_checker.sv
module sdr_bringup_checker #(
  parameter int                ADDR_W    = 12,
  parameter int                BA_W      = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              gnt_o,
  input logic              ready_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o
);
  logic [3:0] code;
  assign code = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  a_r8_gnt_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> ready_o);
  a_r8_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> req_i);
  a_r8_gnt_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> (code == 4'b0111));
  a_r5_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r3_pall_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code == 4'b0010) |=> (code == 4'b0111) && !gnt_o);
  a_r4_ref_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code == 4'b0001) |=> (code == 4'b0111) && !gnt_o);
  a_r2_mode_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code == 4'b0000) |-> (addr_o == MODE_WORD) && (ba_o == '0) && !ready_o);
  a_r7_ref_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code == 4'b0001) |-> (addr_o == '0) && (ba_o == '0));
endmodule

bind sdr_bringup_ctrl sdr_bringup_checker #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o),
  .ready_o(ready_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
  .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o)
);

// File: tb/sdr_bringup_ctrl_test.sv
`timescale 1ns/1ps
module sdr_bringup_ctrl_test;
  localparam int         ADDR_W  = 12;
  localparam int         BA_W    = 2;
  localparam logic [11:0] MODE   = 12'h027;
  localparam int         T_PWRUP = 20;
  localparam int         T_RP    = 3;
  localparam int         T_RFC   = 6;
  localparam int         T_RSA   = 2;
  localparam int         T_REFI  = 60;
  localparam int         N_INIT  = 3;
  localparam logic [3:0] C_NOP = 4'b0111, C_PALL = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  localparam int         N_VEC = 5;
  localparam logic [3:0] VEC_CODE [N_VEC] = '{C_PALL, C_REF, C_REF, C_REF, C_MRS};
  localparam int         VEC_GAP  [N_VEC] = '{T_PWRUP, T_RP, T_RFC, T_RFC, T_RFC};

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b1;
  logic gnt_o, ready_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, dqm_o;
  logic [BA_W-1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0, errors = 0, cyc = 0;
  int n_gnt, n_cke_low, n_dqm_low;
  logic gnt_prev;

  always #2 clk_i = ~clk_i;
  always @(negedge clk_i) cyc++;

  sdr_bringup_ctrl #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE), .T_PWRUP(T_PWRUP), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_RSA(T_RSA), .T_REFI(T_REFI), .N_INIT_REF(N_INIT)
  ) uut (.*);

  wire [3:0] code = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance to the next non-NOP command, tallying the cycles crossed
  task automatic wait_cmd(output int gap);
    gap = 0; n_gnt = 0; n_cke_low = 0; n_dqm_low = 0; gnt_prev = 1'b0;
    do begin
      @(negedge clk_i); #0.5;
      gap++;
      if (code == C_NOP) begin
        if (gnt_o) n_gnt++;
        if (!cke_o) n_cke_low++;
        if (!dqm_o) n_dqm_low++;
        gnt_prev = gnt_o;
      end
    end while (code == C_NOP && gap < 100000);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap, t_pall;
    repeat (3) @(negedge clk_i);
    #0.5;
    chk(code == C_NOP, "R1 nop in reset", code, C_NOP);
    chk(!ready_o && !gnt_o, "R5 ready low in reset", ready_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // start-up command table
    for (int i = 0; i < N_VEC; i++) begin
      wait_cmd(gap);
      chk(code == VEC_CODE[i], "R2 init order", code, VEC_CODE[i]);
      if (i == 0) begin
        chk(gap == VEC_GAP[i], "R1 power-up wait", gap, VEC_GAP[i]);
        chk(n_cke_low == 0 && n_dqm_low == 0, "R1 cke/dqm high", n_cke_low + n_dqm_low, 0);
        chk(addr_o[10] == 1'b1, "R2 all-bank bit", addr_o[10], 1);
      end else if (i == 1) begin
        chk(gap == VEC_GAP[i], "R3 precharge spacing", gap, VEC_GAP[i]);
      end else begin
        chk(gap == VEC_GAP[i], "R4 refresh spacing", gap, VEC_GAP[i]);
      end
      chk(n_gnt == 0 && !ready_o, "R8 no grant before ready", n_gnt, 0);
    end
    chk(addr_o == MODE && ba_o == '0, "R2 mode word", addr_o, MODE);

    gap = 0;
    while (!ready_o && gap < 1000) begin @(negedge clk_i); #0.5; gap++; end
    chk(gap == T_RSA, "R5 ready after mode set", gap, T_RSA);
    chk(!dqm_o, "R5 dqm low when ready", dqm_o, 0);
    chk(gnt_o, "R8 grant when idle", gnt_o, 1);

    // request held high across the refresh deadline
    wait_cmd(gap);
    t_pall = cyc;
    chk(code == C_PALL, "R7 periodic precharge", code, C_PALL);
    chk(gap == T_REFI + 1, "R6 first refresh", gap, T_REFI + 1);
    chk(n_gnt == T_REFI - 1, "R8 grants before due", n_gnt, T_REFI - 1);
    chk(!gnt_prev, "R9 due refresh beats request", gnt_prev, 0);
    wait_cmd(gap);
    chk(code == C_REF && gap == T_RP, "R7 refresh after precharge", gap, T_RP);
    chk(addr_o == '0 && ba_o == '0, "R7 refresh address", addr_o, 0);
    chk(n_gnt == 0, "R9 no grant in refresh", n_gnt, 0);
    gap = 0;
    do begin @(negedge clk_i); #0.5; gap++; end while (!gnt_o && gap < 1000);
    chk(gap == T_RFC, "R4 grant after refresh", gap, T_RFC);

    wait_cmd(gap);
    chk(code == C_PALL && cyc - t_pall == T_REFI, "R6 refresh period", cyc - t_pall, T_REFI);
    wait_cmd(gap);
    repeat (T_RFC + 2) @(negedge clk_i);
    req_i = 1'b0; #0.5;
    chk(!gnt_o, "R8 no grant without request", gnt_o, 0);
    @(negedge clk_i);
    req_i = 1'b1; #0.5;
    chk(gnt_o && ready_o, "R8 grant on request", gnt_o, 1);

    // reset mid-run restarts the bring-up
    @(negedge clk_i);
    rst_ni = 1'b0; #0.5;
    chk(!ready_o && !gnt_o && code == C_NOP, "R5 reset clears ready", ready_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_cmd(gap);
    chk(code == C_PALL && gap == T_PWRUP, "R1 restart wait", gap, T_PWRUP);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule